// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers a parameterised set of peripheral interrupt lines and presents one level interrupt output to each of a small number of processor contexts. Every source passes through a gateway, built as level-high or rising-edge per source, which turns the input into a pending bit. Each context has its own enable bits and a priority threshold. Combinational arbitration picks, for each context, the pending and enabled source that has the highest priority.

Software reaches the block through a plain 32-bit register bus. Every access completes in the cycle it is presented, so there is no back-pressure and no wait state. A read returns data in the same cycle. A write, or the side effect of a claim read, takes effect at the next clock edge. To handle an interrupt, a context reads its claim register, which hands out the winning source ID and takes that source. It then writes the same ID back to finish the interrupt. Between those two steps the source's gateway forwards nothing new.

Source IDs start at 1, and ID 0 means "none". The default build has 31 sources and 2 contexts, with 3-bit priorities. Sources 24 to 31 are built with edge gateways and the others with level gateways.

Top module: `pic_core`

## Requirements
- R1: Reset clears every priority, enable bit, threshold, pending bit and claimed flag. After reset every irq_o bit is 0 and every register reads 0.
- R2: Source n has its priority register at byte address 4*n, and only the low 3 bits are kept. Address 0, addresses past the last source, misaligned addresses and unmapped addresses read 0, and writes to them change nothing.
- R3: The enable word w of context c is at 0x2000 + 0x80*c + 4*w. Source n is bit n%32 of word n/32. The bit for ID 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and keeps its low 3 bits. The claim/complete register of context c is at 0x200000 + 0x1000*c + 4.
- R5: irq_o[c] is 1 exactly when some pending source that is enabled for c has a priority strictly above the threshold of c. A source with priority 0 never counts.
- R6: A claim read returns the ID of the eligible source with the highest priority, taking the lowest ID on a tie, in the same access. It returns 0 when no source is above the threshold, and a read that returns 0 has no effect.
- R7: A claim clears the source's pending bit and blocks its gateway. While the source is blocked it is not pending, and claim reads never return it.
- R8: A completion write acts only if the written ID is enabled for that context at the time of the write. Otherwise the write is ignored and the source stays blocked.
- R9: A level gateway raises pending when its input is high and the source is neither pending nor blocked. Pending then holds until claimed. If the input is still high when the source completes, the source is pending again one cycle later.
- R10: An edge gateway makes one request per rising edge, and the input need not stay high. One edge that arrives while the source is pending or blocked is held and delivered after completion. A steady-high input makes no new request.
- R11: Contexts are independent. The enables and threshold of one context have no effect on the output or claim of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt lines; bit n is source n (1..N_SRC) |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | N_CTX | Level interrupt request per context |

## Verification
The arbiter is tested by raising all sources at once, with priorities spread so that every level 0 to 7 occurs and ties occur. The stream of claim reads must then match the order computed in the bench: descending priority, ascending ID, and priority-0 sources skipped. A second round after all completions separates level gateways, which come back while their input is high, from edge gateways, which do not. A full sweep of priority against threshold separates the strict comparison from a greater-or-equal comparison. The same sweep also checks that the other context stays quiet. Targeted sequences cover a completion ignored because the source is disabled, and an edge held while its source is blocked.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam logic [31:0] PRIO_SPAN  = 32'h0000_1000;
  localparam logic [31:0] ENA_BASE   = 32'h0000_2000;
  localparam logic [31:0] ENA_STRIDE = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_ENA,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] ctx;
    logic [10:0] sel;   // source ID for RK_PRIO, word index for RK_ENA
  } reg_dec_t;

  function automatic reg_dec_t decode(input logic [31:0] a, input int n_src, input int n_ctx);
    reg_dec_t    d;
    logic [31:0] off;
    d      = '0;
    d.kind = RK_NONE;
    off    = '0;
    if (a[1:0] == 2'b00) begin
      if (a < PRIO_SPAN) begin
        if (a[31:2] != 30'd0 && a[31:2] <= 30'(n_src)) begin
          d.kind = RK_PRIO;
          d.sel  = a[12:2];
        end
      end else if (a >= ENA_BASE && a < ENA_BASE + 32'(n_ctx) * ENA_STRIDE) begin
        off   = (a - ENA_BASE) >> 7;
        d.ctx = off[15:0];
        d.sel = {6'd0, a[6:2]};
        if (32'(a[6:2]) * 32 <= 32'(n_src)) d.kind = RK_ENA;
      end else if (a >= CTX_BASE && a < CTX_BASE + 32'(n_ctx) * CTX_STRIDE) begin
        off   = (a - CTX_BASE) >> 12;
        d.ctx = off[15:0];
        if (a[11:0] == 12'h000) d.kind = RK_THR;
        else if (a[11:0] == 12'h004) d.kind = RK_CLAIM;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/pic_gate.sv
module pic_gate #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);

  logic req;

  generate
    if (EDGE) begin : g_edge
      logic src_q, hold_q, rise, take;
      assign rise = src_i & ~src_q;
      assign req  = rise | hold_q;
      assign take = req & ~pend_o & ~busy_o;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          src_q  <= 1'b0;
          hold_q <= 1'b0;
        end else begin
          src_q  <= src_i;
          hold_q <= (hold_q & ~take) | (rise & (pend_o | busy_o | hold_q));
        end
      end
    end else begin : g_level
      assign req = src_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      if (claim_i) begin
        pend_o <= 1'b0;
        busy_o <= 1'b1;
      end else if (req && !pend_o && !busy_o) begin
        pend_o <= 1'b1;
      end
      if (done_i) busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int N_SRC  = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0]             elig_i,
  input  logic [N_SRC:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]          thr_i,
  output logic [IDW-1:0]             win_o,
  output logic                       irq_o
);

  logic [PRIO_W-1:0] best_p;
  logic [IDW-1:0]    best_id;
  logic              unused_zero;

  assign unused_zero = ^{elig_i[0], prio_i[0]};

  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (elig_i[i] && prio_i[i] > best_p) begin
        best_p  = prio_i[i];
        best_id = IDW'(i);
      end
    end
  end

  assign irq_o = best_p > thr_i;
  assign win_o = irq_o ? best_id : '0;

endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int             N_SRC    = 31,
  parameter int             N_CTX    = 2,
  parameter int             PRIO_W   = 3,
  parameter int             ADDR_W   = 24,
  parameter logic [N_SRC:0] EDGE_SRC = 32'hFF00_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC:1]    src_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_CTX-1:0]  irq_o
);
  import pic_pkg::*;

  localparam int IDW = $clog2(N_SRC + 1);
  localparam int CW  = (N_CTX > 1) ? $clog2(N_CTX) : 1;

  logic [N_SRC:0][PRIO_W-1:0] prio_q;
  logic [N_CTX-1:0][N_SRC:0]  en_q;
  logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [N_SRC:0]             pend_v, busy_v, claim_vec, done_vec;
  logic [N_CTX-1:0][IDW-1:0]  win_id;

  reg_dec_t    dec;
  logic [CW-1:0] cx;
  logic        rd_claim, wr_done, unused_bits;

  assign dec         = decode(32'(bus_addr_i), N_SRC, N_CTX);
  assign cx          = dec.ctx[CW-1:0];
  assign rd_claim    = bus_sel_i && !bus_we_i && dec.kind == RK_CLAIM;
  assign wr_done     = bus_sel_i && bus_we_i && dec.kind == RK_CLAIM;
  assign unused_bits = ^{dec.ctx};

  // gateways
  assign pend_v[0] = 1'b0;
  assign busy_v[0] = 1'b0;
  generate
    for (genvar g = 1; g <= N_SRC; g++) begin : g_src
      pic_gate #(.EDGE(EDGE_SRC[g])) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i[g]),
        .claim_i(claim_vec[g]),
        .done_i (done_vec[g]),
        .pend_o (pend_v[g]),
        .busy_o (busy_v[g])
      );
    end
  endgenerate

  // per-context arbitration
  generate
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      pic_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
        .elig_i(pend_v & en_q[c]),
        .prio_i(prio_q),
        .thr_i (thr_q[c]),
        .win_o (win_id[c]),
        .irq_o (irq_o[c])
      );
    end
  endgenerate

  // claim and completion pulses
  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    if (rd_claim) claim_vec[win_id[cx]] = 1'b1;
    if (wr_done && bus_wdata_i != 32'd0 && bus_wdata_i <= 32'(N_SRC)) begin
      if (en_q[cx][bus_wdata_i[IDW-1:0]]) done_vec[bus_wdata_i[IDW-1:0]] = 1'b1;
    end
    claim_vec[0] = 1'b0;
    done_vec[0]  = 1'b0;
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_sel_i && bus_we_i) begin
      unique case (dec.kind)
        RK_PRIO: prio_q[dec.sel[IDW-1:0]] <= bus_wdata_i[PRIO_W-1:0];
        RK_ENA: begin
          for (int s = 1; s <= N_SRC; s++) begin
            if (int'(dec.sel) == s / 32) en_q[cx][s] <= bus_wdata_i[s % 32];
          end
        end
        RK_THR:  thr_q[cx] <= bus_wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // read data
  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (dec.kind)
        RK_PRIO: bus_rdata_o = 32'(prio_q[dec.sel[IDW-1:0]]);
        RK_ENA: begin
          for (int s = 1; s <= N_SRC; s++) begin
            if (int'(dec.sel) == s / 32) bus_rdata_o[s % 32] = en_q[cx][s];
          end
        end
        RK_THR:   bus_rdata_o = 32'(thr_q[cx]);
        RK_CLAIM: bus_rdata_o = 32'(win_id[cx]);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int N_SRC  = 31,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_CTX-1:0]             irq_o,
  input logic [N_CTX-1:0][PRIO_W-1:0] thr_q,
  input logic [N_SRC:0]               pend_v,
  input logic [N_SRC:0]               busy_v,
  input logic [N_SRC:0]               claim_vec
);

  // R7: a blocked source is never pending at the same time
  a_r7_blocked_not_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v & busy_v) == '0);

  // R7: a claimed source is blocked in the next cycle
  a_r7_claim_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_vec != '0 |=> (busy_v & $past(claim_vec)) == $past(claim_vec));

  // R6: one claim read takes at most one source
  a_r6_single_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_vec));

  // R5: a request needs some pending source
  a_r5_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != '0 |-> pend_v != '0);

  generate
    for (genvar c = 0; c < N_CTX; c++) begin : g_thr
      // R5: the top threshold masks every source
      a_r5_top_threshold_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_q[c] == '1 |-> !irq_o[c]);
    end
  endgenerate

endmodule

bind pic_core pic_core_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .thr_q    (thr_q),
  .pend_v   (pend_v),
  .busy_v   (busy_v),
  .claim_vec(claim_vec)
);

// File: tb/pic_core_bench.sv
module pic_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 31;
  localparam int NC = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS:1]   src_i = '0;
  logic          bus_sel_i = 1'b0;
  logic          bus_we_i = 1'b0;
  logic [23:0]   bus_addr_i = '0;
  logic [31:0]   bus_wdata_i = '0;
  logic [31:0]   bus_rdata_o;
  logic [NC-1:0] irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pic_core u_pic_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [23:0] a_prio(int s);  return 24'(s * 4); endfunction
  function automatic logic [23:0] a_ena(int c);   return 24'(32'h2000 + c * 32'h80); endfunction
  function automatic logic [23:0] a_thr(int c);   return 24'(32'h200000 + c * 32'h1000); endfunction
  function automatic logic [23:0] a_clm(int c);   return 24'(32'h200004 + c * 32'h1000); endfunction
  function automatic int prio_of(int s);          return (s * 5 + 3) % 8; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; src_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R2 / R3 / R4: register storage and address decode
    for (int s = 1; s <= NS; s++) wr(a_prio(s), 32'(s * 37 + 8));
    for (int s = 1; s <= NS; s++) begin
      rd(a_prio(s), v);
      chk("R2 prio low bits", v, 32'((s * 37 + 8) % 8));
    end
    wr(a_prio(0), 32'h7);
    rd(a_prio(0), v);       chk("R2 id0 reads 0", v, 0);
    wr(24'h001000, 32'h5);
    rd(24'h001000, v);      chk("R2 unmapped reads 0", v, 0);
    rd(24'h000006, v);      chk("R2 misaligned reads 0", v, 0);
    wr(a_ena(1), 32'hFFFF_FFFF);
    rd(a_ena(1), v);        chk("R3 enable bit0 reserved", v, 32'hFFFF_FFFE);
    rd(a_ena(0), v);        chk("R3 other context enable", v, 0);
    wr(a_thr(0), 32'hFF);
    rd(a_thr(0), v);        chk("R4 threshold low bits", v, 7);
    rd(a_thr(1), v);        chk("R4 other threshold", v, 0);

    // R1: reset clears everything
    do_reset();
    chk("R1 irq after reset", 32'(irq_o), 0);
    rd(a_prio(5), v);       chk("R1 prio after reset", v, 0);
    rd(a_ena(1), v);        chk("R1 enable after reset", v, 0);
    rd(a_thr(0), v);        chk("R1 threshold after reset", v, 0);
    rd(a_clm(0), v);        chk("R1 claim after reset", v, 0);

    // R6 / R7 / R9 / R10: full arbitration order, two rounds
    for (int s = 1; s <= NS; s++) wr(a_prio(s), 32'(prio_of(s)));
    wr(a_ena(0), 32'hFFFF_FFFE);
    @(negedge clk_i); src_i = '1;
    repeat (2) @(negedge clk_i);
    #1 chk("R5 irq with pending", 32'(irq_o), 32'b01);
    for (int p = 7; p >= 1; p--)
      for (int s = 1; s <= NS; s++)
        if (prio_of(s) == p) begin
          rd(a_clm(0), v);
          chk("R6 claim order round1", v, 32'(s));
        end
    rd(a_clm(0), v);        chk("R7 all blocked claim 0", v, 0);
    #1 chk("R7 irq low while blocked", 32'(irq_o), 0);
    for (int s = 1; s <= NS; s++) if (prio_of(s) != 0) wr(a_clm(0), 32'(s));
    @(negedge clk_i);
    for (int p = 7; p >= 1; p--)
      for (int s = 1; s <= 23; s++)
        if (prio_of(s) == p) begin
          rd(a_clm(0), v);
          chk("R9 R10 claim order round2", v, 32'(s));
        end
    rd(a_clm(0), v);        chk("R10 steady edge no request", v, 0);
    @(negedge clk_i); src_i = '0;
    for (int s = 1; s <= 23; s++) if (prio_of(s) != 0) wr(a_clm(0), 32'(s));
    @(negedge clk_i);
    rd(a_clm(0), v);        chk("R9 low input not repended", v, 0);

    // R5 / R11: priority x threshold sweep on context 1
    do_reset();
    wr(a_ena(1), 32'h2);
    @(negedge clk_i); src_i[1] = 1'b1;
    for (int p = 0; p <= 7; p++) begin
      wr(a_prio(1), 32'(p));
      for (int t = 0; t <= 7; t++) begin
        wr(a_thr(1), 32'(t));
        #1 chk("R5 strict threshold", 32'(irq_o[1]), 32'(p > t));
        chk("R11 other context quiet", 32'(irq_o[0]), 0);
        if (p <= t) begin
          rd(a_clm(1), v);
          chk("R6 below threshold claim 0", v, 0);
        end
      end
    end
    rd(a_clm(0), v);        chk("R11 other context claim", v, 0);

    // R8: completion ignored while disabled
    do_reset();
    wr(a_prio(2), 32'h4);
    wr(a_ena(0), 32'h4);
    @(negedge clk_i); src_i[2] = 1'b1;
    rd(a_clm(0), v);        chk("R8 claim source 2", v, 2);
    wr(a_ena(0), 32'h0);
    wr(a_clm(0), 32'h2);
    wr(a_ena(0), 32'h4);
    rd(a_clm(0), v);        chk("R8 ignored completion keeps block", v, 0);
    wr(a_clm(0), 32'h2);
    rd(a_clm(0), v);        chk("R9 repended after completion", v, 2);

    // R10: edge held while blocked
    do_reset();
    wr(a_prio(30), 32'h5);
    wr(a_ena(0), 32'h4000_0000);
    @(negedge clk_i); src_i[30] = 1'b1;
    @(negedge clk_i); src_i[30] = 1'b0;
    rd(a_clm(0), v);        chk("R10 edge pulse claimed", v, 30);
    @(negedge clk_i); src_i[30] = 1'b1;
    @(negedge clk_i); src_i[30] = 1'b0;
    rd(a_clm(0), v);        chk("R10 blocked during edge", v, 0);
    wr(a_clm(0), 32'd30);
    @(negedge clk_i);
    rd(a_clm(0), v);        chk("R10 held edge delivered", v, 30);
    wr(a_clm(0), 32'd30);
    @(negedge clk_i);
    rd(a_clm(0), v);        chk("R10 no extra request", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule